// File: doc/BRIEF.md
# Double-Buffered Audio Playback Controller

This block walks a read pointer through a 2 KB audio sample buffer that firmware treats as two 1 KB halves. While playback runs, every sample tick fetches one stereo frame from the buffer, scales both channels by an 8-bit volume and presents them to a DAC interface, then steps the pointer to the next frame. The most significant pointer bit is the half indicator. Firmware watches it and refills whichever half is not being played.

Playback is driven by three strobes: start, stop and pointer clear. The block also holds a host status byte that is changed by a set mask and a clear mask. It captures a half flag coming from a separate data buffer reader. Both are presented with the audio half indicator in one 16-bit status word. The buffer memory is outside the block: the block drives a byte address and receives the 32-bit frame stored at that address on the same cycle.

Top module: `aud_dbuf_player`

## Requirements
- R1: After reset the read address is 0, playback is stopped, both channel outputs are 0, the status word is 0 and the half indicator is 0.
- R2: While playing, each cycle with `sample_tick` high advances `rd_addr` by 4 bytes on that clock edge. While stopped, `rd_addr` does not move. `start_stb` starts playback and `stop_stb` stops it. When both are high in the same cycle, playback ends up stopped.
- R3: `ptr_clr_stb` sets `rd_addr` to 0 on the next edge. It overrides an advance in the same cycle and does not change whether playback is running.
- R4: The pointer wraps from byte 2044 back to 0. `audio_half` and status bit 14 are 0 while the pointer is in bytes 0..1023 and 1 while it is in bytes 1024..2047, so they toggle at each 1 KB boundary.
- R5: On a playing tick, the frame at the current `rd_addr` is captured. It is little-endian: the left sample is `rd_data[15:0]` and the right sample is `rd_data[31:16]`, both signed. Each output is (sample × volume) shifted right arithmetically by 8 bits, which rounds toward minus infinity. The volume is unsigned (0..255).
- R6: While stopped, both channel outputs read 0. While playing, they hold the value from the last tick until the next tick.
- R7: A write with `stat_wr` makes the status byte (status bits 7:0) its old value OR `stat_set`, with every bit named in `stat_clr` forced to 0. A bit named in both masks ends up 0. With no write, the byte holds.
- R8: Status bit 13 follows the `data_half` input one clock later. Status bits 15, 12, 11, 10, 9 and 8 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_stb | input | 1 | Start or resume playback |
| stop_stb | input | 1 | Stop pointer advance |
| ptr_clr_stb | input | 1 | Return pointer to byte 0 |
| sample_tick | input | 1 | One frame period elapsed |
| volume | input | 8 | Unsigned gain, 255 close to unity |
| stat_wr | input | 1 | Apply the status masks |
| stat_set | input | 8 | Status bits to set |
| stat_clr | input | 8 | Status bits to clear, wins over set |
| data_half | input | 1 | Half flag from the data buffer reader |
| rd_data | input | 32 | Frame stored at `rd_addr` |
| rd_addr | output | 11 | Byte address of the next frame |
| audio_half | output | 1 | Buffer half being played |
| left_out | output | 16 | Scaled left sample |
| right_out | output | 16 | Scaled right sample |
| status | output | 16 | Status byte plus half flags |

## Verification
The hardest event to reach from the ports is the pointer crossing from the last frame of the upper half back to byte 0, because it needs 512 playing ticks. The bench issues back-to-back ticks and tracks the expected address to check the half flag at both boundaries and at the wrap. Collisions are driven in a single cycle so that the priority rules are visible: stop against start, pointer clear against a tick, and a status bit named by both masks. The scaling check uses buffer contents that include negative samples, so the arithmetic shift is tested where it rounds toward minus infinity.

// File: rtl/aud_dbuf_player.sv
module aud_dbuf_player #(
  parameter int ADDR_W        = 11,
  parameter int SAMP_W        = 16,
  parameter int VOL_W         = 8,
  parameter int STAT_W        = 8,
  parameter int AUD_HALF_BIT  = 14,
  parameter int DATA_HALF_BIT = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_stb,
  input  logic                stop_stb,
  input  logic                ptr_clr_stb,
  input  logic                sample_tick,
  input  logic [VOL_W-1:0]    volume,
  input  logic                stat_wr,
  input  logic [STAT_W-1:0]   stat_set,
  input  logic [STAT_W-1:0]   stat_clr,
  input  logic                data_half,
  input  logic [2*SAMP_W-1:0] rd_data,
  output logic [ADDR_W-1:0]   rd_addr,
  output logic                audio_half,
  output logic [SAMP_W-1:0]   left_out,
  output logic [SAMP_W-1:0]   right_out,
  output logic [15:0]         status
);
  localparam int FRAME_BYTES = 2 * SAMP_W / 8;
  localparam int PROD_W      = SAMP_W + VOL_W;

  logic                     playing;
  logic [ADDR_W-1:0]        ptr;
  logic [STAT_W-1:0]        stat_q;
  logic                     dhalf_q;
  logic [SAMP_W-1:0]        left_q, right_q;
  logic signed [PROD_W-1:0] prod_l, prod_r;
  logic signed [PROD_W-1:0] vol_s;

  assign vol_s  = PROD_W'({1'b0, volume});
  assign prod_l = PROD_W'($signed(rd_data[SAMP_W-1:0])) * vol_s;
  assign prod_r = PROD_W'($signed(rd_data[2*SAMP_W-1:SAMP_W])) * vol_s;

  wire unused_low = &{1'b0, prod_l[VOL_W-1:0], prod_r[VOL_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      playing <= 1'b0;
    end else if (stop_stb) begin
      playing <= 1'b0;
    end else if (start_stb) begin
      playing <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ptr_clr_stb) begin
      ptr <= '0;
    end else if (playing && sample_tick) begin
      ptr <= ptr + ADDR_W'(FRAME_BYTES);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
    end else if (playing && sample_tick) begin
      left_q  <= prod_l[PROD_W-1:VOL_W];
      right_q <= prod_r[PROD_W-1:VOL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q  <= '0;
      dhalf_q <= 1'b0;
    end else begin
      dhalf_q <= data_half;
      if (stat_wr) stat_q <= (stat_q | stat_set) & ~stat_clr;
    end
  end

  assign rd_addr    = ptr;
  assign audio_half = ptr[ADDR_W-1];
  assign left_out   = playing ? left_q  : '0;
  assign right_out  = playing ? right_q : '0;

  always_comb begin
    status                = '0;
    status[STAT_W-1:0]    = stat_q;
    status[AUD_HALF_BIT]  = ptr[ADDR_W-1];
    status[DATA_HALF_BIT] = dhalf_q;
  end
endmodule

module aud_dbuf_player_chk #(
  parameter int ADDR_W = 11,
  parameter int SAMP_W = 16,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              playing,
  input logic              stop_stb,
  input logic              ptr_clr_stb,
  input logic              sample_tick,
  input logic              stat_wr,
  input logic [STAT_W-1:0] stat_set,
  input logic [STAT_W-1:0] stat_clr,
  input logic              data_half,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [SAMP_W-1:0] left_out,
  input logic [SAMP_W-1:0] right_out,
  input logic [15:0]       status
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    playing && sample_tick && !ptr_clr_stb |=> rd_addr == $past(rd_addr) + ADDR_W'(4));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !playing && !ptr_clr_stb |=> $stable(rd_addr));

  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr_stb |=> rd_addr == '0);

  p_mute_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_stb |=> left_out == '0 && right_out == '0);

  p_upd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> (status[STAT_W-1:0] & $past(stat_clr)) == '0);

  p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> $stable(status[STAT_W-1:0]));

  p_dhalf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> status[13] == $past(data_half) && status[12:8] == '0 && !status[15]);
endmodule

bind aud_dbuf_player aud_dbuf_player_chk #(
  .ADDR_W(ADDR_W), .SAMP_W(SAMP_W), .STAT_W(STAT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .playing(playing), .stop_stb(stop_stb),
  .ptr_clr_stb(ptr_clr_stb), .sample_tick(sample_tick), .stat_wr(stat_wr),
  .stat_set(stat_set), .stat_clr(stat_clr), .data_half(data_half),
  .rd_addr(rd_addr), .left_out(left_out), .right_out(right_out), .status(status)
);

// File: tb/aud_dbuf_player_tb.sv
module aud_dbuf_player_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_stb = 1'b0, stop_stb = 1'b0, ptr_clr_stb = 1'b0, sample_tick = 1'b0;
  logic [7:0]  volume = 8'd0;
  logic        stat_wr = 1'b0;
  logic [7:0]  stat_set = 8'd0, stat_clr = 8'd0;
  logic        data_half = 1'b0;
  logic [31:0] rd_data;
  logic [10:0] rd_addr;
  logic        audio_half;
  logic [15:0] left_out, right_out, status;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  int exp_addr = 0;

  always #4 clk = ~clk;

  function automatic logic [31:0] frame_at(input logic [10:0] a);
    logic [15:0] l, r;
    l = 16'(int'(a) * 37 - 3000);
    r = 16'(16'h1234 - int'(a) * 53);
    return {r, l};
  endfunction

  assign rd_data = frame_at(rd_addr);

  function automatic logic [15:0] scl(input logic [15:0] s, input logic [7:0] v);
    int p;
    p = int'($signed(s)) * int'(v);
    return 16'(p >>> 8);
  endfunction

  aud_dbuf_player dut_i (
    .clk(clk), .rst_n(rst_n), .start_stb(start_stb), .stop_stb(stop_stb),
    .ptr_clr_stb(ptr_clr_stb), .sample_tick(sample_tick), .volume(volume),
    .stat_wr(stat_wr), .stat_set(stat_set), .stat_clr(stat_clr),
    .data_half(data_half), .rd_data(rd_data), .rd_addr(rd_addr),
    .audio_half(audio_half), .left_out(left_out), .right_out(right_out),
    .status(status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic one_cycle();
    @(negedge clk);
    start_stb = 0; stop_stb = 0; ptr_clr_stb = 0; sample_tick = 0; stat_wr = 0;
  endtask

  task automatic tick_and_check(input string req);
    logic [31:0] f;
    f = frame_at(11'(exp_addr));
    sample_tick = 1;
    one_cycle();
    exp_addr = (exp_addr + 4) % 2048;
    chk({req, " addr"}, 32'(rd_addr), 32'(exp_addr));
    chk({req, " left"}, 32'(left_out), 32'(scl(f[15:0], volume)));
    chk({req, " right"}, 32'(right_out), 32'(scl(f[31:16], volume)));
  endtask

  task automatic t_reset();
    chk("R1 addr", 32'(rd_addr), 0);
    chk("R1 left", 32'(left_out), 0);
    chk("R1 right", 32'(right_out), 0);
    chk("R1 status", 32'(status), 0);
    chk("R1 half", 32'(audio_half), 0);
  endtask

  task automatic t_stopped_tick();
    sample_tick = 1; one_cycle();
    chk("R2 no advance while stopped", 32'(rd_addr), 0);
  endtask

  task automatic t_play();
    volume = 8'd128;
    start_stb = 1; one_cycle();
    for (int i = 0; i < 4; i++) tick_and_check("R2 R5 play");
  endtask

  task automatic t_hold();
    logic [15:0] l0;
    l0 = left_out;
    repeat (3) one_cycle();
    chk("R6 hold between ticks", 32'(left_out), 32'(l0));
    chk("R2 no tick no advance", 32'(rd_addr), 32'(exp_addr));
  endtask

  task automatic t_stop();
    stop_stb = 1; one_cycle();
    chk("R6 left zero stopped", 32'(left_out), 0);
    chk("R6 right zero stopped", 32'(right_out), 0);
    sample_tick = 1; one_cycle();
    chk("R2 stopped tick ignored", 32'(rd_addr), 32'(exp_addr));
    start_stb = 1; stop_stb = 1; one_cycle();
    sample_tick = 1; one_cycle();
    chk("R2 stop wins over start", 32'(rd_addr), 32'(exp_addr));
    chk("R6 still muted", 32'(left_out), 0);
  endtask

  task automatic t_ptr_clr();
    start_stb = 1; one_cycle();
    tick_and_check("R2 resume");
    ptr_clr_stb = 1; sample_tick = 1; one_cycle();
    exp_addr = 0;
    chk("R3 clear beats advance", 32'(rd_addr), 0);
    tick_and_check("R3 still playing after clear");
  endtask

  task automatic t_volume();
    volume = 8'd255; tick_and_check("R5 vol 255");
    volume = 8'd0;   tick_and_check("R5 vol 0");
    volume = 8'd1;   tick_and_check("R5 vol 1 floor");
    volume = 8'd77;  tick_and_check("R5 vol 77");
  endtask

  task automatic t_wrap();
    bit seen_up, seen_down;
    seen_up = 0; seen_down = 0;
    volume = 8'd200;
    ptr_clr_stb = 1; one_cycle();
    exp_addr = 0;
    for (int i = 0; i < 512; i++) begin
      sample_tick = 1; one_cycle();
      exp_addr = (exp_addr + 4) % 2048;
      if (exp_addr == 1024) begin
        seen_up = 1;
        chk("R4 half up at 1024", 32'(audio_half), 1);
        chk("R4 status bit 14 up", 32'(status[14]), 1);
      end
      if (exp_addr == 1020) chk("R4 half low at 1020", 32'(audio_half), 0);
      if (exp_addr == 0) begin
        seen_down = 1;
        chk("R4 wrap to 0", 32'(rd_addr), 0);
        chk("R4 half back to 0", 32'(audio_half), 0);
        chk("R4 status bit 14 down", 32'(status[14]), 0);
      end
    end
    chk("R4 both boundaries reached", 32'({seen_up, seen_down}), 32'h3);
    tick_and_check("R4 R5 after wrap");
  endtask

  task automatic t_status();
    stat_wr = 1; stat_set = 8'h37; stat_clr = 8'h00; one_cycle();
    chk("R7 set", 32'(status[7:0]), 32'h37);
    stat_wr = 1; stat_set = 8'h00; stat_clr = 8'h05; one_cycle();
    chk("R7 clear", 32'(status[7:0]), 32'h32);
    stat_wr = 1; stat_set = 8'h81; stat_clr = 8'h80; one_cycle();
    chk("R7 clear wins", 32'(status[7:0]), 32'h33);
    stat_set = 8'hFF; stat_clr = 8'h00; one_cycle();
    chk("R7 no write holds", 32'(status[7:0]), 32'h33);
  endtask

  task automatic t_data_half();
    data_half = 1; one_cycle();
    chk("R8 data half set", 32'(status[13]), 1);
    chk("R8 reserved zero", 32'({status[15], status[12:8]}), 0);
    data_half = 0; one_cycle();
    chk("R8 data half clear", 32'(status[13]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_stopped_tick();
    t_play();
    t_hold();
    t_stop();
    t_ptr_clr();
    t_volume();
    t_wrap();
    t_status();
    t_data_half();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule